// File: doc/BRIEF.md
# Performance Counter Bank with Overflow Reporting

This block is a small bank of event counters for a processor core. A parameterised number of general-purpose counters each have their own event-select register. A parameterised number of fixed-function counters share a single control register made of packed 4-bit fields. Every counter also has a bit in a global enable mask, and it advances only when both that bit and its own local enable are set. Each cycle, every counter lane receives a small increment value. A single privilege input says whether the cycle belongs to kernel or user code, and each counter can be set to count in either mode, in both, or in neither.

When a counter wraps past all-ones, it sets a sticky bit in a global status register. Software clears these bits by writing ones to a separate clear register. A level interrupt output stays high while any uncleared status bit belongs to a counter whose interrupt enable is set. Software can preset a counter to a negative value so that it overflows after a known number of events. A general-purpose counter can also be given a threshold, and it then counts cycles in which the increment reaches the threshold, one per cycle, instead of summing the increments. Access is through a simple write strobe with a combinational read port.

Top module: `perfmon_bank`

## Requirements
- R1: Event select i (address 0x08+i) holds a 16-bit event code in bits [15:0], user-count in bit 16, kernel-count in bit 17, interrupt enable in bit 20, local enable in bit 22 and an 8-bit threshold in bits [31:24]. With the threshold at zero, an enabled counter adds its lane increment in every cycle whose privilege (priv_kern=1 for kernel, 0 for user) has its count bit set. In every other cycle it adds nothing.
- R2: Fixed counter j (address 0x10+j) is controlled by bits [4j+3:4j] of the fixed control register (address 0x18). Bit 0 of the field counts kernel cycles, bit 1 counts user cycles and bit 3 enables the interrupt.
- R3: The global enable register is at address 0x19. General-purpose counter i uses global bit i and fixed counter j uses global bit 32+j. A counter whose global bit is clear does not advance, whatever its local enable says.
- R4: A counter whose value passes from all-ones through zero sets its bit in the status register (address 0x1A, same bit numbering as R3). That bit stays set until a one is written to the same bit of the clear register (address 0x1B).
- R5: An overflow on a counter whose interrupt enable is clear still sets its status bit but does not raise ovf_irq.
- R6: ovf_irq is a level. It is high while any set status bit belongs to a counter whose interrupt enable is set, and it falls once those bits are cleared or their enables are removed.
- R7: A counter preset to 2^W−k overflows on the event that takes it past all-ones, and it keeps the remainder (2^W−2 plus 5 reads 3).
- R8: With a non-zero threshold, a general-purpose counter advances by exactly one in each qualifying cycle whose increment is at least the threshold, and by zero otherwise.
- R9: A write to a counter takes effect in the next cycle even while the counter is running. A write takes priority over an increment in the same cycle, and counting then continues from the written value.
- R10: After reset, every register reads zero and ovf_irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| priv_kern | input | 1 | 1 = current cycle is kernel mode, 0 = user mode |
| gp_evt_inc | input | NUM_GP*INC_W | Per-cycle increment for each general-purpose lane |
| fx_evt_inc | input | NUM_FX*INC_W | Per-cycle increment for each fixed lane |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr (combinational) |
| ovf_irq | output | 1 | Level overflow interrupt |

## Verification
The bench sweeps every combination of the kernel and user count bits against both privilege levels and all increment values. A design that swapped the two mode bits or ignored the privilege would miscount there. A second sweep pairs every non-zero threshold with every increment, which catches off-by-one compares and designs that add the raw increment. Overflow is exercised from negative presets on both counter kinds, with and without the interrupt enable, to catch a status bit that is lost, an interrupt that fires without its enable, or a remainder that is dropped. A write made in the same cycle as an increment, and a cleared global bit on one lane while its neighbour counts, expose a wrong write priority and gating that has been mapped to the wrong bit.

// File: rtl/perfmon_pkg.sv
// Shared constants for the performance counter bank: register addresses,
// event-select field positions and fixed-control field layout.
package perfmon_pkg;
    localparam int unsigned ADDR_W      = 5;
    localparam int unsigned DATA_W      = 64;
    localparam int unsigned GLB_W       = 64;
    localparam int unsigned FX_GLB_BASE = 32;

    localparam logic [ADDR_W-1:0] A_GP_CNT   = 5'h00;
    localparam logic [ADDR_W-1:0] A_GP_SEL   = 5'h08;
    localparam logic [ADDR_W-1:0] A_FX_CNT   = 5'h10;
    localparam logic [ADDR_W-1:0] A_FX_CTRL  = 5'h18;
    localparam logic [ADDR_W-1:0] A_GLB_EN   = 5'h19;
    localparam logic [ADDR_W-1:0] A_STATUS   = 5'h1A;
    localparam logic [ADDR_W-1:0] A_STAT_CLR = 5'h1B;

    localparam int unsigned SEL_USER    = 16;
    localparam int unsigned SEL_KERN    = 17;
    localparam int unsigned SEL_IRQ     = 20;
    localparam int unsigned SEL_EN      = 22;
    localparam int unsigned SEL_THR_LSB = 24;
    localparam int unsigned THR_W       = 8;

    localparam int unsigned FXF_W    = 4;
    localparam int unsigned FXF_KERN = 0;
    localparam int unsigned FXF_USER = 1;
    localparam int unsigned FXF_IRQ  = 3;
endpackage

// File: rtl/perfmon_gate.sv
// Turns one lane's raw increment into the amount its counter adds this cycle.
// Assumes: thresh of zero means "add the raw increment"; a non-zero
// thresh means "add one when inc >= thresh". Purely combinational.
module perfmon_gate
    import perfmon_pkg::*;
#(
    parameter int unsigned INC_W = 3
) (
    input  logic [INC_W-1:0] inc,
    input  logic [THR_W-1:0] thresh,
    input  logic             local_en,
    input  logic             glb_en,
    input  logic             kern_ok,
    input  logic             user_ok,
    input  logic             priv_kern,
    output logic [INC_W-1:0] amt
);
    localparam int unsigned CMP_W = INC_W + THR_W;

    logic live;
    logic [CMP_W-1:0] inc_x;
    logic [CMP_W-1:0] thr_x;

    // Qualify by both enables and the privilege filter, then apply threshold.
    always_comb begin
        live  = local_en && glb_en && (priv_kern ? kern_ok : user_ok);
        inc_x = CMP_W'(inc);
        thr_x = CMP_W'(thresh);
        if (!live)
            amt = '0;
        else if (thresh == '0)
            amt = inc;
        else
            amt = (inc_x >= thr_x) ? INC_W'(1) : '0;
    end
endmodule

// File: rtl/perfmon_counter.sv
// One counter register. A write takes priority over the increment in the
// same cycle; wrap pulses when an increment carries out of the top bit.
// Assumes: amt is already gated.
module perfmon_counter #(
    parameter int unsigned CNT_W = 48,
    parameter int unsigned INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [INC_W-1:0] amt,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W:0] sum;

    // Next value with carry out.
    always_comb begin
        sum  = {1'b0, cnt} + (CNT_W+1)'(amt);
        wrap = !wr_en && sum[CNT_W];
    end

    // Counter register: reset, software write, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_en)
            cnt <= wr_val;
        else
            cnt <= sum[CNT_W-1:0];
    end
endmodule

// File: rtl/perfmon_bank.sv
// Bank of general-purpose and fixed event counters with a global enable
// mask, sticky overflow status with write-one-to-clear, and a level
// overflow interrupt. Assumes NUM_GP <= 8 and NUM_FX <= 8.
module perfmon_bank
    import perfmon_pkg::*;
#(
    parameter int unsigned NUM_GP = 2,
    parameter int unsigned NUM_FX = 2,
    parameter int unsigned CNT_W  = 48,
    parameter int unsigned INC_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    priv_kern,
    input  logic [NUM_GP*INC_W-1:0] gp_evt_inc,
    input  logic [NUM_FX*INC_W-1:0] fx_evt_inc,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    ovf_irq
);
    logic [DATA_W-1:0] gp_sel [NUM_GP];
    logic [DATA_W-1:0] fx_ctrl;
    logic [GLB_W-1:0]  glb_en;
    logic [GLB_W-1:0]  status;
    logic [GLB_W-1:0]  ie;
    logic [GLB_W-1:0]  wrap_vec;
    logic [CNT_W-1:0]  gp_cnt [NUM_GP];
    logic [CNT_W-1:0]  fx_cnt [NUM_FX];
    logic [NUM_GP-1:0] gp_wrap;
    logic [NUM_FX-1:0] fx_wrap;
    logic [NUM_GP-1:0] gp_irq_en;
    logic [NUM_FX-1:0] fx_irq_en;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_GP; gi++) begin : g_gp
            logic             wr_cnt;
            logic             wr_sel;
            logic [INC_W-1:0] amt;

            assign wr_cnt        = bus_we && (bus_addr == ADDR_W'(A_GP_CNT + gi));
            assign wr_sel        = bus_we && (bus_addr == ADDR_W'(A_GP_SEL + gi));
            assign gp_irq_en[gi] = gp_sel[gi][SEL_IRQ];

            // Event-select register for this lane.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    gp_sel[gi] <= '0;
                else if (wr_sel)
                    gp_sel[gi] <= bus_wdata;
            end

            perfmon_gate #(.INC_W(INC_W)) u_gate (
                .inc       (gp_evt_inc[gi*INC_W +: INC_W]),
                .thresh    (gp_sel[gi][SEL_THR_LSB +: THR_W]),
                .local_en  (gp_sel[gi][SEL_EN]),
                .glb_en    (glb_en[gi]),
                .kern_ok   (gp_sel[gi][SEL_KERN]),
                .user_ok   (gp_sel[gi][SEL_USER]),
                .priv_kern (priv_kern),
                .amt       (amt)
            );

            perfmon_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (wr_cnt),
                .wr_val (bus_wdata[CNT_W-1:0]),
                .amt    (amt),
                .cnt    (gp_cnt[gi]),
                .wrap   (gp_wrap[gi])
            );
        end

        for (gi = 0; gi < NUM_FX; gi++) begin : g_fx
            logic             wr_cnt;
            logic [INC_W-1:0] amt;
            logic [FXF_W-1:0] fld;

            assign wr_cnt        = bus_we && (bus_addr == ADDR_W'(A_FX_CNT + gi));
            assign fld           = fx_ctrl[gi*FXF_W +: FXF_W];
            assign fx_irq_en[gi] = fld[FXF_IRQ];

            perfmon_gate #(.INC_W(INC_W)) u_gate (
                .inc       (fx_evt_inc[gi*INC_W +: INC_W]),
                .thresh    ('0),
                .local_en  (1'b1),
                .glb_en    (glb_en[FX_GLB_BASE + gi]),
                .kern_ok   (fld[FXF_KERN]),
                .user_ok   (fld[FXF_USER]),
                .priv_kern (priv_kern),
                .amt       (amt)
            );

            perfmon_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (wr_cnt),
                .wr_val (bus_wdata[CNT_W-1:0]),
                .amt    (amt),
                .cnt    (fx_cnt[gi]),
                .wrap   (fx_wrap[gi])
            );
        end
    endgenerate

    // Spread per-lane wrap and interrupt-enable bits onto global numbering.
    always_comb begin
        wrap_vec = '0;
        ie       = '0;
        for (int i = 0; i < NUM_GP; i++) begin
            wrap_vec[i] = gp_wrap[i];
            ie[i]       = gp_irq_en[i];
        end
        for (int j = 0; j < NUM_FX; j++) begin
            wrap_vec[FX_GLB_BASE + j] = fx_wrap[j];
            ie[FX_GLB_BASE + j]       = fx_irq_en[j];
        end
    end

    // Shared control registers: fixed control and global enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fx_ctrl <= '0;
            glb_en  <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_FX_CTRL) fx_ctrl <= bus_wdata;
            if (bus_addr == A_GLB_EN)  glb_en  <= bus_wdata;
        end
    end

    // Sticky status: a new wrap wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else if (bus_we && bus_addr == A_STAT_CLR)
            status <= (status & ~bus_wdata) | wrap_vec;
        else
            status <= status | wrap_vec;
    end

    assign ovf_irq = |(status & ie);

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_GP; i++) begin
            if (bus_addr == ADDR_W'(A_GP_CNT + i)) bus_rdata = DATA_W'(gp_cnt[i]);
            if (bus_addr == ADDR_W'(A_GP_SEL + i)) bus_rdata = gp_sel[i];
        end
        for (int j = 0; j < NUM_FX; j++)
            if (bus_addr == ADDR_W'(A_FX_CNT + j)) bus_rdata = DATA_W'(fx_cnt[j]);
        if (bus_addr == A_FX_CTRL) bus_rdata = fx_ctrl;
        if (bus_addr == A_GLB_EN)  bus_rdata = glb_en;
        if (bus_addr == A_STATUS)  bus_rdata = status;
    end
endmodule

// Checker for perfmon_bank: status stickiness, gating hold, write priority
// and interrupt release after a full clear.
module perfmon_bank_chk
    import perfmon_pkg::*;
#(
    parameter int unsigned CNT_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              ovf_irq,
    input logic [GLB_W-1:0]  status,
    input logic              glb0,
    input logic [CNT_W-1:0]  gp0_cnt
);
    assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_STAT_CLR) |=> ((status & $past(status)) == $past(status)));

    assert_global_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb0 && !(bus_we && bus_addr == A_GP_CNT)) |=> $stable(gp0_cnt));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_GP_CNT) |=> (gp0_cnt == $past(bus_wdata[CNT_W-1:0])));

    assert_irq_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_STAT_CLR && bus_wdata == '1) |=> !ovf_irq);
endmodule

bind perfmon_bank perfmon_bank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ovf_irq   (ovf_irq),
    .status    (status),
    .glb0      (glb_en[0]),
    .gp0_cnt   (gp_cnt[0])
);

// File: tb/perfmon_bank_bench.sv
`timescale 1ns/1ps
module perfmon_bank_bench;
    localparam int unsigned INC_W = 3;
    localparam logic [63:0] MASK48 = 64'h0000_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv_kern = 1'b0;
    logic [5:0]  gp_evt_inc = '0;
    logic [5:0]  fx_evt_inc = '0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        ovf_irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    perfmon_bank u_perfmon_bank (
        .clk(clk), .rst_n(rst_n), .priv_kern(priv_kern),
        .gp_evt_inc(gp_evt_inc), .fx_evt_inc(fx_evt_inc),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ovf_irq(ovf_irq)
    );

    function automatic logic [63:0] mk_sel(input bit en, input bit k, input bit u,
                                           input bit irq, input int thr);
        logic [63:0] v;
        v = 64'h00C0;
        v[16] = u; v[17] = k; v[20] = irq; v[22] = en;
        v[31:24] = 8'(thr);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input logic [2:0] g0, input logic [2:0] g1, input logic [2:0] f0,
                       input logic [2:0] f1, input logic p, input logic we,
                       input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        gp_evt_inc = {g1, g0}; fx_evt_inc = {f1, f0}; priv_kern = p;
        bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #0.5;
        gp_evt_inc = '0; fx_evt_inc = '0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] d);
        cyc(0, 0, 0, 0, 0, 1'b1, a, d);
    endtask

    task automatic rd(input logic [4:0] a, output logic [63:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10: reset state of every register and the interrupt
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), v);
            chk($sformatf("R10 reset addr %0h", a), v, 64'h0);
        end
        chk("R10 irq after reset", {63'h0, ovf_irq}, 64'h0);

        wr(5'h19, 64'h0000_0003_0000_0003);
        rd(5'h19, v); chk("R3 global enable readback", v, 64'h0000_0003_0000_0003);

        // R1: privilege filter sweep on GP counter 0
        for (int ku = 0; ku < 4; ku++)
            for (int p = 0; p < 2; p++)
                for (int inc = 0; inc < 8; inc++) begin
                    bit k = ku[1]; bit u = ku[0];
                    wr(5'h00, 64'h0);
                    wr(5'h08, mk_sel(1, k, u, 0, 0));
                    cyc(3'(inc), 0, 0, 0, p[0], 0, 0, 0);
                    rd(5'h00, v);
                    chk($sformatf("R1 k=%0d u=%0d p=%0d inc=%0d", k, u, p, inc), v,
                        ((p == 1 && k) || (p == 0 && u)) ? 64'(inc) : 64'h0);
                end

        // R1: local enable clear blocks counting
        wr(5'h00, 64'h0);
        wr(5'h08, mk_sel(0, 1, 1, 0, 0));
        cyc(5, 0, 0, 0, 1, 0, 0, 0);
        rd(5'h00, v); chk("R1 local enable off", v, 64'h0);

        // R8: threshold sweep
        for (int thr = 1; thr < 8; thr++)
            for (int inc = 0; inc < 8; inc++) begin
                wr(5'h00, 64'h0);
                wr(5'h08, mk_sel(1, 1, 1, 0, thr));
                cyc(3'(inc), 0, 0, 0, 1, 0, 0, 0);
                rd(5'h00, v);
                chk($sformatf("R8 thr=%0d inc=%0d", thr, inc), v, (inc >= thr) ? 64'h1 : 64'h0);
            end

        // R3: clearing global bit 0 stops GP0 but GP1 still counts
        wr(5'h00, 64'h0); wr(5'h01, 64'h0);
        wr(5'h08, mk_sel(1, 1, 1, 0, 0));
        wr(5'h09, mk_sel(1, 1, 1, 0, 0));
        wr(5'h19, 64'h0000_0003_0000_0002);
        cyc(4, 6, 0, 0, 0, 0, 0, 0);
        rd(5'h00, v); chk("R3 GP0 gated by global bit 0", v, 64'h0);
        rd(5'h01, v); chk("R3 GP1 counts with global bit 1", v, 64'h6);
        wr(5'h19, 64'h0000_0003_0000_0003);

        // R2/R3: fixed counter 1 kernel bit at field bit 4; fixed 0 field empty
        wr(5'h18, 64'h10);
        cyc(0, 0, 3, 2, 1, 0, 0, 0);
        rd(5'h11, v); chk("R2 fixed1 kernel count", v, 64'h2);
        rd(5'h10, v); chk("R2 fixed0 field clear", v, 64'h0);
        cyc(0, 0, 3, 2, 0, 0, 0, 0);
        rd(5'h11, v); chk("R2 fixed1 user cycle ignored", v, 64'h2);
        wr(5'h18, 64'h20);
        cyc(0, 0, 0, 5, 0, 0, 0, 0);
        rd(5'h11, v); chk("R2 fixed1 user count", v, 64'h7);
        wr(5'h19, 64'h0000_0001_0000_0003);
        cyc(0, 0, 0, 5, 0, 0, 0, 0);
        rd(5'h11, v); chk("R3 fixed1 gated by global bit 33", v, 64'h7);
        wr(5'h19, 64'h0000_0003_0000_0003);

        // R5/R7: GP1 preset to -2, irq disabled, +5 -> 3 with status set
        wr(5'h09, mk_sel(1, 1, 1, 0, 0));
        wr(5'h01, MASK48 - 64'h1);
        cyc(0, 5, 0, 0, 1, 0, 0, 0);
        rd(5'h01, v); chk("R7 remainder after wrap", v, 64'h3);
        rd(5'h1A, v); chk("R4 status bit 1 set", v, 64'h2);
        chk("R5 no irq without enable", {63'h0, ovf_irq}, 64'h0);
        cyc(0, 2, 0, 0, 1, 0, 0, 0);
        rd(5'h01, v); chk("R7 keeps counting after wrap", v, 64'h5);
        rd(5'h1A, v); chk("R4 status sticky", v, 64'h2);

        // R6: enabling the interrupt exposes the pending status
        wr(5'h09, mk_sel(1, 1, 1, 1, 0));
        chk("R6 irq high with enabled pending status", {63'h0, ovf_irq}, 64'h1);
        wr(5'h1B, 64'h1);
        rd(5'h1A, v); chk("R4 clear of other bit leaves status", v, 64'h2);
        chk("R6 irq still high", {63'h0, ovf_irq}, 64'h1);
        wr(5'h1B, 64'h2);
        rd(5'h1A, v); chk("R4 status cleared by W1C", v, 64'h0);
        chk("R6 irq drops after clear", {63'h0, ovf_irq}, 64'h0);

        // R4/R6/R7: fixed 0 preset all-ones with interrupt bit, one event wraps
        wr(5'h18, 64'h9);
        wr(5'h10, MASK48);
        cyc(0, 0, 1, 0, 1, 0, 0, 0);
        rd(5'h10, v); chk("R7 fixed0 wraps to zero", v, 64'h0);
        rd(5'h1A, v); chk("R4 status bit 32 set", v, 64'h0000_0001_0000_0000);
        chk("R6 irq from fixed0", {63'h0, ovf_irq}, 64'h1);
        wr(5'h1B, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R6 irq drops after full clear", {63'h0, ovf_irq}, 64'h0);

        // R9: write wins over simultaneous increment, then counting continues
        wr(5'h08, mk_sel(1, 1, 1, 0, 0));
        wr(5'h00, 64'h10);
        cyc(7, 0, 0, 0, 1, 1'b1, 5'h00, 64'd100);
        rd(5'h00, v); chk("R9 write wins", v, 64'd100);
        cyc(2, 0, 0, 0, 1, 0, 0, 0);
        rd(5'h00, v); chk("R9 counts from written value", v, 64'd102);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule